// File: doc/BRIEF.md
# Watchdog Timeout Generator with Paired-Clear Mode

This block counts ticks from one of two selectable sources and raises a reset request when software stops servicing it. The first source is a free-running tick from a separate low-speed oscillator, modelled here as a pulse input. The second is the instruction clock, which is the core clock divided by four. The selected tick drives an 8-bit divider and then a 7-bit prescaler. A 3-bit field in a software-visible byte picks the prescaler tap, so the timeout period can be set anywhere from 256 to 32768 ticks in powers of two.

Software services the watchdog with clear commands. A configuration input chooses the clear style. In single mode, one clear command is enough. In paired mode, two distinct commands must both arrive before the count restarts. The external reset pin and the HALT command also restart the count.

When the count expires, the block pulses a full chip-reset request while the core runs. While the core is halted, it pulses a warm-reset request instead. It also keeps two hardware status flags that software cannot write: a timeout flag and a power-down flag. Software reads these after a reset to learn its cause.

Top module: `wdt_core`

## Requirements
- R1: After the synchronous power-on reset `rst`, the timeout flag, the power-down flag, both reset requests and the select byte all read zero.
- R2: With `en_opt_i` high, a timeout occurs on the N-th counted tick since the last restart, where N = 256 * 2^k and k is bits 2..0 of the select byte. Code 0 gives 256 ticks and code 7 gives 32768 ticks.
- R3: With `src_sel_i`=0, the counted tick is `wdt_tick_i`. With `src_sel_i`=1, the counted tick is one `clk` cycle in every four, the first one falling in the fourth cycle after `rst` is released.
- R4: A timeout is reported in the cycle after the last tick, as a one-cycle pulse, and counting then resumes from zero.
- R5: A timeout with `halted_i`=0 pulses `chip_rst_o`, and a timeout with `halted_i`=1 pulses `warm_rst_o`. Both cases set the timeout flag. The two outputs are never high together.
- R6: In single mode (`dual_clr_i`=0), `clr_i` restarts the count and clears both flags. `clr_a_i` and `clr_b_i` have no effect in this mode.
- R7: In paired mode (`dual_clr_i`=1), the restart and flag clearing take place only once both `clr_a_i` and `clr_b_i` have been seen, in either order or in the same cycle. After that, the pairing starts over. `clr_i` has no effect in this mode.
- R8: `ext_rst_i` restarts the count and leaves the flags unchanged. `halt_cmd_i` restarts the count, sets the power-down flag and clears the timeout flag.
- R9: With `en_opt_i`=0, no tick is counted, no timeout occurs, and the clear commands change neither the count nor the flags.
- R10: With the instruction-clock source selected and `halted_i`=1, counting stops. With the free tick selected, counting continues while halted.
- R11: A write stores all 8 bits of the select byte and reads them back in the next cycle. Bits 7..3 have no effect on the timeout period.
- R12: A restart (clear, external reset or HALT) in the same cycle as the final tick suppresses that timeout. A HALT in the same cycle as a completed clear leaves the power-down flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| en_opt_i | input | 1 | Watchdog enable option |
| src_sel_i | input | 1 | Tick source: 0 free tick, 1 instruction clock |
| dual_clr_i | input | 1 | Clear style: 0 single command, 1 paired commands |
| wdt_tick_i | input | 1 | One-cycle pulse from the free-running watchdog oscillator |
| halted_i | input | 1 | Core is in HALT |
| halt_cmd_i | input | 1 | HALT command executed (one-cycle pulse) |
| ext_rst_i | input | 1 | External reset pin asserted |
| clr_i | input | 1 | Single clear command |
| clr_a_i | input | 1 | First paired clear command |
| clr_b_i | input | 1 | Second paired clear command |
| sel_wr_i | input | 1 | Write strobe for the select byte |
| sel_wdata_i | input | 8 | Select byte write data; bits 2..0 pick the tap |
| sel_rdata_o | output | 8 | Select byte read data |
| chip_rst_o | output | 1 | Full chip-reset request pulse |
| warm_rst_o | output | 1 | Warm-reset request pulse (PC and SP only) |
| to_flag_o | output | 1 | Timeout flag |
| pdf_flag_o | output | 1 | Power-down flag |

## Verification
The bench checks every output against its own model on every cycle, so any fault in the internal state shows up at the ports.

A divider or prescaler that skips a tick, or restarts at the wrong time, moves the timeout pulse. The bench sees this on the exact cycle the pulse was expected, at most one period of the selected tap later. A pairing register that holds stale state, or fails to clear, makes a clear take effect one command early or not at all. This shows up at once on the flags, and at the next expected timeout on the reset outputs. A wrong HALT qualification sends the pulse to the other reset output in the same cycle the timeout occurs.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DIV_W  = 8;
    localparam int PRE_W  = 7;
    localparam int SEL_W  = 3;
    localparam int REG_W  = 8;
    localparam int IDIV   = 4;

    typedef enum logic {
        SRC_FREE  = 1'b0,
        SRC_INSTR = 1'b1
    } src_e;

    typedef enum logic {
        CLR_SINGLE = 1'b0,
        CLR_PAIRED = 1'b1
    } clr_mode_e;

    typedef struct packed {
        logic clr;
        logic clr_a;
        logic clr_b;
    } clr_cmd_t;

    typedef struct packed {
        logic timeout;
        logic pdown;
    } wdt_flags_t;

    // Low `code` bits set: prescaler bits that must be all ones at the tap
    function automatic logic [PRE_W-1:0] tap_mask(input logic [SEL_W-1:0] code);
        logic [PRE_W:0] one_hot;
        one_hot = (PRE_W+1)'(1) << code;
        return PRE_W'(one_hot - 1'b1);
    endfunction

endpackage

// File: rtl/wdt_tick_src.sv
module wdt_tick_src
    import wdt_pkg::*;
#(
    parameter int INSTR_DIV = IDIV
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  src_e src_i,
    input  logic halted_i,
    input  logic free_tick_i,
    output logic tick_o
);
    localparam int PH_W = (INSTR_DIV > 1) ? $clog2(INSTR_DIV) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(INSTR_DIV - 1);

    logic [PH_W-1:0] phase_q;
    logic            instr_tick;

    always_ff @(posedge clk) begin
        if (rst || phase_q == PH_LAST) phase_q <= '0;
        else                           phase_q <= phase_q + 1'b1;
    end

    assign instr_tick = (phase_q == PH_LAST);

    always_comb begin
        tick_o = 1'b0;
        if (en_i) begin
            unique case (src_i)
                SRC_FREE:  tick_o = free_tick_i;
                SRC_INSTR: tick_o = instr_tick && !halted_i;
            endcase
        end
    end

    // R3: the instruction tick recurs only after a full phase cycle
    a_r3_instr_spacing: assert property (@(posedge clk) disable iff (rst)
        instr_tick |=> !instr_tick);

endmodule

// File: rtl/wdt_clear_ctl.sv
module wdt_clear_ctl
    import wdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en_i,
    input  clr_mode_e mode_i,
    input  clr_cmd_t  cmd_i,
    output logic      fire_o
);
    logic seen_a_q, seen_b_q;
    logic have_a, have_b;

    assign have_a = cmd_i.clr_a || seen_a_q;
    assign have_b = cmd_i.clr_b || seen_b_q;

    always_comb begin
        fire_o = 1'b0;
        if (en_i) begin
            unique case (mode_i)
                CLR_SINGLE: fire_o = cmd_i.clr;
                CLR_PAIRED: fire_o = have_a && have_b;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || fire_o || mode_i == CLR_SINGLE) begin
            seen_a_q <= 1'b0;
            seen_b_q <= 1'b0;
        end else if (en_i) begin
            seen_a_q <= have_a;
            seen_b_q <= have_b;
        end
    end

    // R7: a paired clear always completes on a command in the current cycle
    a_r7_pair_needs_live_cmd: assert property (@(posedge clk) disable iff (rst)
        (fire_o && mode_i == CLR_PAIRED) |-> (cmd_i.clr_a || cmd_i.clr_b));

    // R7: after a completed clear the pairing state is empty
    a_r7_pair_restart: assert property (@(posedge clk) disable iff (rst)
        fire_o |=> (!seen_a_q && !seen_b_q));

endmodule

// File: rtl/wdt_chain.sv
module wdt_chain
    import wdt_pkg::*;
#(
    parameter int D_W = DIV_W,
    parameter int P_W = PRE_W,
    parameter int S_W = SEL_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick_i,
    input  logic           restart_i,
    input  logic [S_W-1:0] code_i,
    output logic           fire_o
);
    logic [D_W-1:0] div_q;
    logic [P_W-1:0] pre_q;
    logic           div_wrap;
    logic           tap_full;
    logic [P_W-1:0] mask;

    assign mask     = P_W'(tap_mask(SEL_W'(code_i)));
    assign div_wrap = &div_q;
    assign tap_full = &(pre_q | ~mask);
    assign fire_o   = tick_i && !restart_i && div_wrap && tap_full;

    always_ff @(posedge clk) begin
        if (rst || restart_i || fire_o) begin
            div_q <= '0;
            pre_q <= '0;
        end else if (tick_i) begin
            div_q <= div_q + 1'b1;
            if (div_wrap) pre_q <= pre_q + 1'b1;
        end
    end

    // R4: the count resumes from zero after a timeout
    a_r4_zero_after_fire: assert property (@(posedge clk) disable iff (rst)
        fire_o |=> (div_q == '0 && pre_q == '0));

    // R8: any restart empties the divider and prescaler
    a_r8_restart_clears: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (div_q == '0 && pre_q == '0));

    // R9: without a tick the count cannot move
    a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !restart_i) |=> ($stable(div_q) && $stable(pre_q)));

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en_opt_i,
    input  logic             src_sel_i,
    input  logic             dual_clr_i,
    input  logic             wdt_tick_i,
    input  logic             halted_i,
    input  logic             halt_cmd_i,
    input  logic             ext_rst_i,
    input  logic             clr_i,
    input  logic             clr_a_i,
    input  logic             clr_b_i,
    input  logic             sel_wr_i,
    input  logic [REG_W-1:0] sel_wdata_i,
    output logic [REG_W-1:0] sel_rdata_o,
    output logic             chip_rst_o,
    output logic             warm_rst_o,
    output logic             to_flag_o,
    output logic             pdf_flag_o
);
    logic [REG_W-1:0] sel_q;
    logic             tick;
    logic             clr_fire;
    logic             restart;
    logic             fire;
    logic             chip_q, warm_q;
    wdt_flags_t       flags_q;
    clr_cmd_t         cmds;

    assign cmds = '{clr: clr_i, clr_a: clr_a_i, clr_b: clr_b_i};

    always_ff @(posedge clk) begin
        if (rst)           sel_q <= '0;
        else if (sel_wr_i) sel_q <= sel_wdata_i;
    end

    wdt_tick_src #(.INSTR_DIV(IDIV)) u_src (
        .clk         (clk),
        .rst         (rst),
        .en_i        (en_opt_i),
        .src_i       (src_e'(src_sel_i)),
        .halted_i    (halted_i),
        .free_tick_i (wdt_tick_i),
        .tick_o      (tick)
    );

    wdt_clear_ctl u_clr (
        .clk    (clk),
        .rst    (rst),
        .en_i   (en_opt_i),
        .mode_i (clr_mode_e'(dual_clr_i)),
        .cmd_i  (cmds),
        .fire_o (clr_fire)
    );

    assign restart = ext_rst_i || halt_cmd_i || clr_fire;

    wdt_chain #(.D_W(DIV_W), .P_W(PRE_W), .S_W(SEL_W)) u_chain (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick),
        .restart_i (restart),
        .code_i    (sel_q[SEL_W-1:0]),
        .fire_o    (fire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            chip_q  <= 1'b0;
            warm_q  <= 1'b0;
            flags_q <= '0;
        end else begin
            chip_q <= fire && !halted_i;
            warm_q <= fire && halted_i;
            if (halt_cmd_i) begin
                flags_q.pdown   <= 1'b1;
                flags_q.timeout <= 1'b0;
            end else if (clr_fire) begin
                flags_q <= '0;
            end else if (fire) begin
                flags_q.timeout <= 1'b1;
            end
        end
    end

    assign sel_rdata_o = sel_q;
    assign chip_rst_o  = chip_q;
    assign warm_rst_o  = warm_q;
    assign to_flag_o   = flags_q.timeout;
    assign pdf_flag_o  = flags_q.pdown;

    // R5: only one kind of reset request at a time
    a_r5_one_kind: assert property (@(posedge clk) disable iff (rst)
        !(chip_rst_o && warm_rst_o));

    // R5: a reset request always comes with the timeout flag set
    a_r5_flag_with_pulse: assert property (@(posedge clk) disable iff (rst)
        (chip_rst_o || warm_rst_o) |-> to_flag_o);

    // R4: reset requests last a single cycle
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (chip_rst_o || warm_rst_o) |=> !(chip_rst_o || warm_rst_o));

    // R8: HALT sets the power-down flag and drops the timeout flag
    a_r8_halt_flags: assert property (@(posedge clk) disable iff (rst)
        halt_cmd_i |=> (pdf_flag_o && !to_flag_o));

    // R9: while disabled, the flags only move on a HALT
    a_r9_disabled_flags: assert property (@(posedge clk) disable iff (rst)
        (!en_opt_i && !halt_cmd_i) |=> ($stable(to_flag_o) && $stable(pdf_flag_o)));

endmodule

// File: tb/wdt_core_tb_top.sv
module wdt_core_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       en_opt, src_sel, dual_clr, wtick, halted, halt_cmd, ext_rst;
    logic       clr, clr_a, clr_b, sel_wr;
    logic [7:0] sel_wdata;
    logic [7:0] sel_rdata;
    logic       chip_rst, warm_rst, to_flag, pdf_flag;

    int    checks = 0;
    int    errors = 0;
    int    cyc    = 0;
    int    tick_div = 0;
    bit    started = 0;
    bit    done    = 0;
    string req = "R1";

    // reference model state
    int m_cnt, m_ph, m_sel;
    bit m_to, m_pdf, m_chip, m_warm, m_sa, m_sb;

    always #2.5 clk = ~clk;

    wdt_core dut_i (
        .clk(clk), .rst(rst), .en_opt_i(en_opt), .src_sel_i(src_sel),
        .dual_clr_i(dual_clr), .wdt_tick_i(wtick), .halted_i(halted),
        .halt_cmd_i(halt_cmd), .ext_rst_i(ext_rst), .clr_i(clr),
        .clr_a_i(clr_a), .clr_b_i(clr_b), .sel_wr_i(sel_wr),
        .sel_wdata_i(sel_wdata), .sel_rdata_o(sel_rdata),
        .chip_rst_o(chip_rst), .warm_rst_o(warm_rst),
        .to_flag_o(to_flag), .pdf_flag_o(pdf_flag)
    );

    // behavioural model: total ticks since restart, timeout on multiples of the period
    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_ph = 0; m_sel = 0;
            m_to = 0; m_pdf = 0; m_chip = 0; m_warm = 0; m_sa = 0; m_sb = 0;
        end else begin
            bit itick, tk, cf, rs, fr;
            int period;
            itick = (m_ph == 3);
            m_ph  = (m_ph + 1) % 4;
            tk = en_opt && (src_sel ? (itick && !halted) : wtick);
            period = 256 << (m_sel % 8);
            if (!en_opt)       cf = 0;
            else if (dual_clr) cf = (clr_a || m_sa) && (clr_b || m_sb);
            else               cf = clr;
            if (cf || !dual_clr) begin m_sa = 0; m_sb = 0; end
            else if (en_opt) begin m_sa = m_sa || clr_a; m_sb = m_sb || clr_b; end
            rs = ext_rst || halt_cmd || cf;
            fr = 0;
            if (rs) m_cnt = 0;
            else if (tk) begin
                m_cnt = m_cnt + 1;
                if (m_cnt == period) begin fr = 1; m_cnt = 0; end
            end
            m_chip = fr && !halted;
            m_warm = fr && halted;
            if (halt_cmd)  begin m_pdf = 1; m_to = 0; end
            else if (cf)   begin m_pdf = 0; m_to = 0; end
            else if (fr)   m_to = 1;
            if (sel_wr) m_sel = sel_wdata;
            started = 1;
        end
    end

    task automatic chk(string name, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, name, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (started && !rst) begin
            chk("chip_rst", chip_rst, m_chip);
            chk("warm_rst", warm_rst, m_warm);
            chk("to_flag",  to_flag,  m_to);
            chk("pdf_flag", pdf_flag, m_pdf);
            chk("sel_rdata", sel_rdata, m_sel);
        end
        if (tick_div == 0)      wtick = 0;
        else if (tick_div == 1) wtick = 1;
        else                    wtick = (cyc % tick_div) == 0;
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr(int which);
        @(negedge clk);
        clr   = (which == 0);
        clr_a = (which == 1) || (which == 3);
        clr_b = (which == 2) || (which == 3);
        @(negedge clk);
        clr = 0; clr_a = 0; clr_b = 0;
    endtask

    task automatic write_sel(logic [7:0] v);
        @(negedge clk);
        sel_wr = 1; sel_wdata = v;
        @(negedge clk);
        sel_wr = 0;
    endtask

    task automatic do_halt();
        @(negedge clk);
        halt_cmd = 1;
        @(negedge clk);
        halt_cmd = 0;
    endtask

    initial begin
        rst = 1; en_opt = 1; src_sel = 1; dual_clr = 0; halted = 0;
        halt_cmd = 0; ext_rst = 0; clr = 0; clr_a = 0; clr_b = 0;
        sel_wr = 0; sel_wdata = 0; wtick = 0;
        step(3);
        rst = 0;
        step(1);
        req = "R1";
        chk("reset chip_rst", chip_rst, 0);
        chk("reset to_flag", to_flag, 0);
        chk("reset pdf_flag", pdf_flag, 0);
        chk("reset sel_rdata", sel_rdata, 0);

        req = "R3"; // instruction clock, code 0: timeout after 1024 clk cycles
        step(2100);

        req = "R2"; src_sel = 0; tick_div = 1;
        write_sel(8'h01); pulse_clr(0);
        step(1200);
        write_sel(8'h03); pulse_clr(0);
        step(4200);
        tick_div = 3; write_sel(8'h00);
        step(1600);

        req = "R4"; tick_div = 1;
        step(600);

        req = "R6"; write_sel(8'h02);
        step(500); pulse_clr(0); step(700); pulse_clr(1); pulse_clr(2);
        step(400);

        req = "R7"; dual_clr = 1;
        pulse_clr(0); step(100); pulse_clr(1); step(300); pulse_clr(2);
        step(300); pulse_clr(2); step(200); pulse_clr(1);
        step(500); pulse_clr(3); step(1100);
        dual_clr = 0;

        req = "R8"; write_sel(8'h00);
        step(100); @(negedge clk); ext_rst = 1; @(negedge clk); ext_rst = 0;
        step(300); do_halt(); step(50);

        req = "R5"; halted = 1;
        step(600); halted = 0; do_halt(); pulse_clr(0);

        req = "R10"; src_sel = 1; halted = 1;
        step(3000); halted = 0; step(1200); src_sel = 0;

        req = "R9"; en_opt = 0;
        step(800); pulse_clr(0); step(300); en_opt = 1;
        step(400);

        req = "R11"; write_sel(8'hF8); step(300); write_sel(8'hA9); step(600);

        req = "R12"; write_sel(8'h00); tick_div = 1;
        pulse_clr(0); step(254);
        @(negedge clk); clr = 1; @(negedge clk); clr = 0;
        step(254);
        @(negedge clk); halt_cmd = 1; clr = 1; @(negedge clk); halt_cmd = 0; clr = 0;
        begin
            logic [15:0] lfsr = 16'hACE1;
            for (int i = 0; i < 6000; i++) begin
                @(negedge clk);
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                clr      = (lfsr[7:0] == 8'h11);
                clr_a    = (lfsr[7:0] == 8'h22);
                clr_b    = (lfsr[7:0] == 8'h33);
                halt_cmd = (lfsr[9:0] == 10'h155);
                ext_rst  = (lfsr[9:0] == 10'h2AA);
                if (lfsr[11:0] == 12'h0F0) dual_clr = ~dual_clr;
                if (lfsr[11:0] == 12'h707) halted = ~halted;
                if (lfsr[11:0] == 12'h3C3) src_sel = ~src_sel;
            end
        end
        clr = 0; clr_a = 0; clr_b = 0; halt_cmd = 0; ext_rst = 0;
        step(5);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, actual cycle %0d expected below 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule